// File: doc/BRIEF.md
# NAND Sector ECC Syndrome Corrector

This block judges the error-correcting code of one NAND sector after the sector has been read. A hardware parity generator, which is not part of this block, produces a raw 32-bit parity word over the data. The block removes the two reserved nibbles from that word, packs it into a 24-bit code and inverts it. An erased sector therefore checks clean. It then XORs this code with the three code bytes stored in the spare area, and classifies the resulting syndrome as one of four cases: clean, one data bit in error, damage to the stored code only, or uncorrectable.

For a single data-bit error, the block gives the byte offset and a one-hot bit mask. A streaming port then carries the sector bytes through and flips that bit on the matching beat. The host pulses `start` with both codes present. One cycle later `result_valid` strobes and the verdict is held. The host then streams the sector through the port.

Top module: `nand_ecc_corrector`

## Requirements
- R1: The computed code takes raw parity bits 11:0 as code bits 11:0 and raw bits 27:16 as code bits 23:12; raw bits 31:28 and 15:12 have no effect on the verdict.
- R2: The packed code is inverted in all 24 bits, so a raw parity of zero against a stored code of 0xFFFFFF reports clean.
- R3: The stored code enters as 24 bits with byte 0 in bits 7:0. The syndrome is computed XOR stored, and a zero syndrome gives status 00.
- R4: When syndrome bits 23:12 are the exact bitwise complement of bits 11:0 and the offset is in range, status is 01. `fix_offset` is syndrome bits 23:15 and `fix_mask` is 1 shifted left by syndrome bits 14:12. For every other status both fields read zero.
- R5: A complement-pattern syndrome whose offset is not below SECTOR_BYTES gives status 11.
- R6: A syndrome with exactly one bit set gives status 10, and no stream byte is altered.
- R7: Every other nonzero syndrome gives status 11.
- R8: `result_valid` is high for exactly the one cycle after a `start` pulse. Status, offset and mask hold until the next `start`.
- R9: After `start`, stream beats are counted from 0. Each accepted byte appears on `out_byte` one cycle later with `out_valid`. The byte is XORed with `fix_mask` only on the beat whose count equals `fix_offset`, and only while status is 01. All other bytes pass unchanged.
- R10: A synchronous active-high `rst` clears the status, the offset, the mask, the beat counter, `result_valid` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse to evaluate the codes |
| raw_parity | input | 32 | Raw parity word from the parity generator |
| stored_code | input | 24 | Stored code, byte 0 in bits 7:0 |
| result_valid | output | 1 | One-cycle strobe after start |
| status | output | 2 | 00 clean, 01 data fixed, 10 code-only, 11 uncorrectable |
| fix_offset | output | 9 | Byte offset of the failing bit |
| fix_mask | output | 8 | One-hot mask of the failing bit |
| in_valid | input | 1 | Stream byte valid |
| in_byte | input | 8 | Stream byte in |
| out_valid | output | 1 | Stream byte out valid |
| out_byte | output | 8 | Stream byte out, corrected |

## Verification
The bench builds the block with SECTOR_BYTES = 256. With that value, half of the nine-bit offset field is out of range, so random complement-pattern syndromes reach both the correctable path and the out-of-range failure path. At the default of 512, every offset decodes as in range. A full 256-byte stream follows each verdict, so flips at offset 0, at the last byte, and the absence of flips for the other statuses are all observed at the ports.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int CODE_W = 24;
  localparam int HALF_W = 12;
  localparam int OFS_W  = 9;
  localparam int BIT_W  = 3;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'b00,
    ST_DATA_FIX = 2'b01,
    ST_CODE_FIX = 2'b10,
    ST_FAIL     = 2'b11
  } ecc_status_e;

  // Drop the reserved nibbles and invert so erased pages match.
  function automatic logic [CODE_W-1:0] pack_invert(input logic [31:0] raw);
    return ~{raw[27:16], raw[11:0]};
  endfunction

  function automatic logic has_one_bit(input logic [CODE_W-1:0] v);
    return (v != '0) && ((v & (v - 1'b1)) == '0);
  endfunction
endpackage

// File: rtl/ecc_code_pack.sv
module ecc_code_pack
  import nand_ecc_pkg::*;
(
  input  logic [31:0]       raw_parity,
  output logic [CODE_W-1:0] calc_code
);
  always_comb calc_code = pack_invert(raw_parity);
endmodule

// File: rtl/ecc_syndrome_decode.sv
module ecc_syndrome_decode
  import nand_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic [CODE_W-1:0] calc_code,
  input  logic [CODE_W-1:0] stored_code,
  output logic [CODE_W-1:0] syndrome,
  output logic              syn_zero,
  output logic              syn_pair,
  output logic              syn_single,
  output logic              ofs_in_range,
  output ecc_status_e       verdict,
  output logic [OFS_W-1:0]  bad_offset,
  output logic [7:0]        bad_mask
);
  localparam logic [OFS_W:0] LIMIT = (OFS_W+1)'(SECTOR_BYTES);

  always_comb begin
    syndrome     = calc_code ^ stored_code;
    syn_zero     = (syndrome == '0);
    syn_pair     = ((syndrome[CODE_W-1:HALF_W] ^ syndrome[HALF_W-1:0]) == '1);
    syn_single   = has_one_bit(syndrome);
    bad_offset   = syndrome[CODE_W-1:HALF_W+BIT_W];
    bad_mask     = 8'b1 << syndrome[HALF_W+BIT_W-1:HALF_W];
    ofs_in_range = ({1'b0, bad_offset} < LIMIT);
    if (syn_zero)                  verdict = ST_CLEAN;
    else if (syn_pair)             verdict = ofs_in_range ? ST_DATA_FIX : ST_FAIL;
    else if (syn_single)           verdict = ST_CODE_FIX;
    else                           verdict = ST_FAIL;
  end
endmodule

// File: rtl/ecc_stream_fix.sv
module ecc_stream_fix
  import nand_ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             fix_en,
  input  logic [OFS_W-1:0] fix_offset,
  input  logic [7:0]       fix_mask,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             beat_hit,
  output logic             out_valid,
  output logic [7:0]       out_byte
);
  logic [OFS_W-1:0] beat_cnt;

  always_comb beat_hit = in_valid && fix_en && (beat_cnt == fix_offset);

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_cnt  <= '0;
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_byte <= in_byte ^ (beat_hit ? fix_mask : 8'h00);
      if (restart)       beat_cnt <= '0;
      else if (in_valid) beat_cnt <= beat_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/nand_ecc_corrector.sv
module nand_ecc_corrector
  import nand_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] raw_parity,
  input  logic [23:0] stored_code,
  output logic        result_valid,
  output logic [1:0]  status,
  output logic [8:0]  fix_offset,
  output logic [7:0]  fix_mask,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        out_valid,
  output logic [7:0]  out_byte
);
  logic [CODE_W-1:0] calc_code;
  logic [CODE_W-1:0] syndrome;
  logic              syn_zero, syn_pair, syn_single, ofs_in_range;
  ecc_status_e       verdict;
  logic [OFS_W-1:0]  bad_offset;
  logic [7:0]        bad_mask;
  ecc_status_e       status_q;
  logic              beat_hit;
  logic              fix_en;

  ecc_code_pack u_pack (
    .raw_parity (raw_parity),
    .calc_code  (calc_code)
  );

  ecc_syndrome_decode #(.SECTOR_BYTES(SECTOR_BYTES)) u_dec (
    .calc_code    (calc_code),
    .stored_code  (stored_code),
    .syndrome     (syndrome),
    .syn_zero     (syn_zero),
    .syn_pair     (syn_pair),
    .syn_single   (syn_single),
    .ofs_in_range (ofs_in_range),
    .verdict      (verdict),
    .bad_offset   (bad_offset),
    .bad_mask     (bad_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q     <= ST_CLEAN;
      fix_offset   <= '0;
      fix_mask     <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= start;
      if (start) begin
        status_q   <= verdict;
        fix_offset <= (verdict == ST_DATA_FIX) ? bad_offset : '0;
        fix_mask   <= (verdict == ST_DATA_FIX) ? bad_mask : '0;
      end
    end
  end

  always_comb begin
    status = status_q;
    fix_en = (status_q == ST_DATA_FIX);
  end

  ecc_stream_fix u_stream (
    .clk        (clk),
    .rst        (rst),
    .restart    (start),
    .fix_en     (fix_en),
    .fix_offset (fix_offset),
    .fix_mask   (fix_mask),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .beat_hit   (beat_hit),
    .out_valid  (out_valid),
    .out_byte   (out_byte)
  );
endmodule

// File: rtl/nand_ecc_corrector_chk.sv
module nand_ecc_corrector_chk #(
  parameter int SECTOR_BYTES = 512
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       result_valid,
  input logic [1:0] status,
  input logic [8:0] fix_offset,
  input logic [7:0] fix_mask,
  input logic       in_valid,
  input logic [7:0] in_byte,
  input logic       out_valid,
  input logic [7:0] out_byte,
  input logic       beat_hit
);
  AST_START_STROBE: assert property (@(posedge clk) disable iff (rst) start |=> result_valid); // R8
  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (rst) !start |=> !result_valid); // R8
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (rst) !start |=> $stable(status) && $stable(fix_offset)); // R8
  AST_MASK_ONE_HOT: assert property (@(posedge clk) disable iff (rst) (status == 2'b01) |-> $countones(fix_mask) == 1); // R4
  AST_FIELDS_IDLE: assert property (@(posedge clk) disable iff (rst) (status != 2'b01) |-> (fix_mask == 8'h00 && fix_offset == 9'd0)); // R4
  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (rst) (status == 2'b01) |-> ({23'd0, fix_offset} < SECTOR_BYTES)); // R5
  AST_PASS_UNCHANGED: assert property (@(posedge clk) disable iff (rst) (in_valid && !beat_hit) |=> (out_valid && out_byte == $past(in_byte))); // R9
  AST_NO_FIX_OFF_STATUS: assert property (@(posedge clk) disable iff (rst) (status != 2'b01) |-> !beat_hit); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!result_valid && !out_valid && status == 2'b00)); // R10
endmodule

bind nand_ecc_corrector nand_ecc_corrector_chk #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .result_valid (result_valid),
  .status       (status),
  .fix_offset   (fix_offset),
  .fix_mask     (fix_mask),
  .in_valid     (in_valid),
  .in_byte      (in_byte),
  .out_valid    (out_valid),
  .out_byte     (out_byte),
  .beat_hit     (beat_hit)
);

// File: tb/sim_nand_ecc_corrector.sv
`timescale 1ns/1ps
module sim_nand_ecc_corrector;
  localparam int SECT = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] raw_parity = '0;
  logic [23:0] stored_code = '0;
  logic        result_valid;
  logic [1:0]  status;
  logic [8:0]  fix_offset;
  logic [7:0]  fix_mask;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        out_valid;
  logic [7:0]  out_byte;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nand_ecc_corrector #(.SECTOR_BYTES(SECT)) u0 (
    .clk(clk), .rst(rst), .start(start), .raw_parity(raw_parity),
    .stored_code(stored_code), .result_valid(result_valid), .status(status),
    .fix_offset(fix_offset), .fix_mask(fix_mask), .in_valid(in_valid),
    .in_byte(in_byte), .out_valid(out_valid), .out_byte(out_byte)
  );

  function automatic logic [23:0] ref_code(input logic [31:0] raw);
    logic [23:0] c;
    for (int i = 0; i < 24; i++) c[i] = !raw[(i < 12) ? i : i + 4];
    return c;
  endfunction

  function automatic logic [1:0] ref_class(input logic [23:0] s);
    int ones;
    ones = 0;
    for (int i = 0; i < 24; i++) ones += int'(s[i]);
    if (s == 24'd0) return 2'b00;
    if ((s[23:12] ^ s[11:0]) == 12'hFFF) return (int'(s[23:15]) < SECT) ? 2'b01 : 2'b11;
    if (ones == 1) return 2'b10;
    return 2'b11;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_trial(input string req, input logic [31:0] raw, input logic [23:0] syn);
    logic [1:0] ec;
    logic [8:0] eo;
    logic [7:0] em;
    int bad;
    ec = ref_class(syn);
    eo = (ec == 2'b01) ? syn[23:15] : 9'd0;
    em = (ec == 2'b01) ? (8'd1 << syn[14:12]) : 8'd0;
    @(negedge clk);
    raw_parity  = raw;
    stored_code = ref_code(raw) ^ syn;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " R8 strobe"}, {31'd0, result_valid}, 32'd1);
    check({req, " status"}, {30'd0, status}, {30'd0, ec});
    check({req, " R4 offset/mask"}, {15'd0, fix_offset, fix_mask}, {15'd0, eo, em});
    @(negedge clk);
    check({req, " R8 single strobe"}, {31'd0, result_valid}, 32'd0);
    bad = 0;
    for (int k = 0; k < SECT; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      in_valid = 1'b1;
      in_byte  = d;
      @(negedge clk);
      if (!out_valid || out_byte !== (d ^ ((ec == 2'b01 && k == int'(eo)) ? em : 8'h00))) bad++;
    end
    in_valid = 1'b0;
    check({req, " R9 stream"}, bad, 0);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check("R10 reset status", {30'd0, status}, 0);
    check("R10 reset strobe", {31'd0, result_valid}, 0);
    check("R10 reset stream", {31'd0, out_valid}, 0);
    rst = 1'b0;

    // R2 erased sector: raw zero, stored all ones
    run_trial("R2 erased", 32'h0000_0000, 24'd0);
    // R1 reserved nibbles ignored
    run_trial("R1 reserved", 32'hF000_F000, 24'd0);
    @(negedge clk);
    raw_parity = 32'h0ABC_0DEF; stored_code = 24'h543210; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R1 R3 packing", {30'd0, status}, 0);
    // R4 corner offsets
    run_trial("R4 offset0 bit0", $urandom, {9'd0, 3'd0, 12'hFFF});
    run_trial("R4 last byte bit7", $urandom, {9'd255, 3'd7, ~{9'd255, 3'd7}});
    // R5 out of range
    run_trial("R5 range", $urandom, {9'd256, 3'd2, ~{9'd256, 3'd2}});
    // R6 code-only
    run_trial("R6 single", $urandom, 24'h000001);
    run_trial("R6 single high", $urandom, 24'h800000);
    // R7 two bits
    run_trial("R7 double", $urandom, 24'h000003);

    for (int t = 0; t < 40; t++) begin
      logic [23:0] syn;
      logic [11:0] hi;
      case ($urandom % 4)
        0: syn = 24'd0;
        1: syn = 24'd1 << ($urandom % 24);
        2: begin hi = 12'($urandom); syn = {hi, ~hi}; end
        default: syn = 24'($urandom);
      endcase
      run_trial("R3 R4 R5 R6 R7 random", $urandom, syn);
    end

    // R10 reset after an error verdict
    @(negedge clk);
    raw_parity = 32'd0; stored_code = 24'hFFFFFF ^ {9'd3, 3'd1, ~{9'd3, 3'd1}}; start = 1'b1;
    @(negedge clk); start = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 mid reset status", {30'd0, status}, 0);
    check("R10 mid reset mask", {24'd0, fix_mask}, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule